// File: doc/BRIEF.md
# Memory Response Reordering Buffer

This block sits between the stage that sends memory requests out and the stage that writes results back into the register file. The memory system may complete accesses in any order. The block hands completions to writeback either in program order or in the order they arrive, and a static mode input selects which. Each request brings a sequence tag that grows by one for every later request, and a kind: load, store, atomic or fence. Every completion returns the tag and kind of its request.

In program-order mode a slot is reserved when a request issues, and the slot's done flag is raised when its response comes back. Only the oldest slot can leave, and only once it is done. In arrival-order mode completions are queued as they come back. Loads and atomics go into one queue and stores into another, and the load queue has priority at the writeback port. In both modes a load-class counter and a store counter hold back issue once the configured number of accesses of that class are outstanding.

Top module: `respOrderBuf`

## Requirements
- R1: After reset, wbValid is low, errBadResp is low and issueReady is high for every kind. arrivalMode low selects program-order delivery, and arrivalMode is changed only while reset is held.
- R2: Kind encoding: 0 load, 1 store, 2 atomic, 3 fence. In program-order mode every accepted non-fence request reserves a slot with its done flag clear. A fence reserves no slot and never blocks the requests after it from retiring.
- R3: In program-order mode, wbValid is high only when the oldest outstanding slot is done. Writeback then delivers tags strictly in issue order, whatever order the responses come in.
- R4: In program-order mode, a response whose tag matches no outstanding slot, or matches a slot already marked done, drives errBadResp high in that same cycle and changes no slot.
- R5: In arrival-order mode, load and atomic responses enter a load queue and store responses enter a store queue. Each queue is delivered in the order its responses arrived, and wbValid rises in the cycle after the first response.
- R6: In arrival-order mode, while the load queue holds an entry it is offered at writeback. The store queue head is offered only when the load queue is empty.
- R7: A load or atomic issue is not ready while QUEUE_SIZE load-class requests are in flight. A store issue is not ready while QUEUE_SIZE stores are in flight. A fence is never held back by these limits.
- R8: A request stops counting as in flight in the cycle it retires through writeback. issueReady is decided from the count at the start of the cycle, so a retirement and an issue stalled at the limit in the same cycle leave that issue stalled until the next cycle.
- R9: In program-order mode, a non-fence issue is not ready while all SLOT_DEPTH slots are reserved, even when both counters are below their limit.
- R10: An entry leaves only in a cycle where wbValid and wbReady are both high. In program-order mode, while wbReady is low the offered tag and kind hold.
- R11: In program-order mode, a response may mark the second-oldest slot done in the same cycle that the oldest retires. The next cycle then offers that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| arrivalMode | input | 1 | 1 selects arrival-order delivery, 0 program order |
| issueValid | input | 1 | A request is presented for issue |
| issueTag | input | TAG_W | Sequence tag of the issuing request |
| issueKind | input | 2 | Kind of the issuing request |
| issueReady | output | 1 | Issue is accepted this cycle when valid |
| respValid | input | 1 | A memory response is presented |
| respTag | input | TAG_W | Tag of the completed request |
| respKind | input | 2 | Kind of the completed request |
| wbValid | output | 1 | A completion is offered to writeback |
| wbReady | input | 1 | Writeback takes the offered completion |
| wbTag | output | TAG_W | Tag of the offered completion |
| wbKind | output | 2 | Kind of the offered completion |
| errBadResp | output | 1 | Response has no place to go (protocol error) |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is marking a slot done and retiring the oldest slot. The bench sends the response for the second-oldest tag while it accepts the oldest at writeback, then expects that second tag to be offered one cycle later. The second pair is an issue stalled at the in-flight limit and a retirement of the same class. The bench presents a load while a load retires at full count. It expects issueReady to stay low in that cycle and to rise in the next. Around these cases the bench runs every one of the 24 response orders of four requests in both modes and computes the delivery sequence each one should give.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_ATOMIC = 2'd2,
    OP_FENCE  = 2'd3
  } opKind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic useSlot;
    logic allocSlot;
    logic markDone;
    logic popSlot;
    logic pushLd;
    logic pushSt;
    logic popLd;
    logic popSt;
    logic selSt;
  } robStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic slotFree;
    logic respHit;
    logic headDone;
    logic ldAny;
    logic ldFull;
    logic stAny;
    logic stFull;
  } robStatus_t;

  function automatic logic isLoadClass(input logic [1:0] k);
    return (k == OP_LOAD) || (k == OP_ATOMIC);
  endfunction
endpackage

// File: rtl/rob_arrival_fifo.sv
module rob_arrival_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         notEmpty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] cnt;
  logic          doPush, doPop;

  assign notEmpty = (cnt != '0);
  assign full     = (cnt == CAP);
  assign dout     = mem[rdPtr];
  assign doPush   = push && !full;
  assign doPop    = pop && notEmpty;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      cnt <= cnt + CW'(doPush) - CW'(doPop);
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);

  // R10
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> notEmpty);
endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int TAG_W      = 8,
  parameter int SLOT_DEPTH = 4,
  parameter int QUEUE_SIZE = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  robStrobe_t       stb,
  input  logic [TAG_W-1:0] issueTag,
  input  logic [1:0]       issueKind,
  input  logic [TAG_W-1:0] respTag,
  input  logic [1:0]       respKind,
  output robStatus_t       st,
  output logic [TAG_W-1:0] wbTag,
  output logic [1:0]       wbKind
);
  localparam int EW = TAG_W + 2;
  localparam int SA = (SLOT_DEPTH > 1) ? $clog2(SLOT_DEPTH) : 1;

  logic [SLOT_DEPTH-1:0] busy, done;
  logic [EW-1:0]         slotEnt [SLOT_DEPTH];
  logic [SA-1:0]         headPtr, tailPtr, hitIdx;
  logic                  hit;

  // tag lookup over the outstanding slots
  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = 0; i < SLOT_DEPTH; i++) begin
      if (busy[i] && !done[i] && slotEnt[i][EW-1:2] == respTag) begin
        hit    = 1'b1;
        hitIdx = SA'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.allocSlot) slotEnt[tailPtr] <= {issueTag, issueKind};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= '0;
      done    <= '0;
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (stb.allocSlot) begin
        busy[tailPtr] <= 1'b1;
        done[tailPtr] <= 1'b0;
        tailPtr       <= tailPtr + 1'b1;
      end
      if (stb.markDone) done[hitIdx] <= 1'b1;
      if (stb.popSlot) begin
        busy[headPtr] <= 1'b0;
        headPtr       <= headPtr + 1'b1;
      end
    end
  end

  // arrival queues: index 0 holds loads and atomics, index 1 holds stores
  logic [1:0]    qPush, qPop, qAny, qFull;
  logic [EW-1:0] qOut [2];

  assign qPush = {stb.pushSt, stb.pushLd};
  assign qPop  = {stb.popSt, stb.popLd};

  for (genvar g = 0; g < 2; g++) begin : g_arrq
    rob_arrival_fifo #(.DEPTH(QUEUE_SIZE), .W(EW)) i_q (
      .clk(clk), .rstN(rstN),
      .push(qPush[g]), .din({respTag, respKind}),
      .pop(qPop[g]), .dout(qOut[g]),
      .notEmpty(qAny[g]), .full(qFull[g])
    );
  end

  assign st.slotFree = !busy[tailPtr];
  assign st.respHit  = hit;
  assign st.headDone = busy[headPtr] && done[headPtr];
  assign st.ldAny    = qAny[0];
  assign st.ldFull   = qFull[0];
  assign st.stAny    = qAny[1];
  assign st.stFull   = qFull[1];

  logic [EW-1:0] outEnt;
  assign outEnt = stb.useSlot ? slotEnt[headPtr] : (stb.selSt ? qOut[1] : qOut[0]);
  assign wbTag  = outEnt[EW-1:2];
  assign wbKind = outEnt[1:0];

  // R3
  head_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.popSlot |-> (busy[headPtr] && done[headPtr]));

  // R2
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.allocSlot |=> busy[$past(tailPtr)] && !done[$past(tailPtr)]);
endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int QUEUE_SIZE = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       arrivalMode,
  input  logic       issueValid,
  input  logic [1:0] issueKind,
  input  logic       respValid,
  input  logic [1:0] respKind,
  input  logic       wbReady,
  input  logic [1:0] wbKind,
  input  robStatus_t st,
  output robStrobe_t stb,
  output logic       issueReady,
  output logic       wbValid,
  output logic       errBadResp
);
  localparam int CW = $clog2(QUEUE_SIZE + 1);
  localparam logic [CW-1:0] CAP = CW'(QUEUE_SIZE);

  logic [CW-1:0] loadCnt, storeCnt;
  logic issueFence, issueLd, issueSt, capOk, bufOk, issueFire;
  logic respLd, respSt, wbFire, incLd, incSt, decLd, decSt;

  assign issueFence = (issueKind == OP_FENCE);
  assign issueLd    = isLoadClass(issueKind);
  assign issueSt    = (issueKind == OP_STORE);
  assign capOk      = issueLd ? (loadCnt < CAP) : (issueSt ? (storeCnt < CAP) : 1'b1);
  assign bufOk      = arrivalMode || issueFence || st.slotFree;
  assign issueReady = capOk && bufOk;
  assign issueFire  = issueValid && issueReady;

  assign respLd = isLoadClass(respKind);
  assign respSt = (respKind == OP_STORE);

  assign wbValid = arrivalMode ? (st.ldAny || st.stAny) : st.headDone;
  assign wbFire  = wbValid && wbReady;

  always_comb begin
    stb           = '0;
    stb.useSlot   = !arrivalMode;
    stb.selSt     = !st.ldAny;
    stb.allocSlot = issueFire && !arrivalMode && !issueFence;
    stb.markDone  = respValid && !arrivalMode && st.respHit;
    stb.pushLd    = respValid && arrivalMode && respLd;
    stb.pushSt    = respValid && arrivalMode && respSt;
    stb.popSlot   = wbFire && !arrivalMode;
    stb.popLd     = wbFire && arrivalMode && st.ldAny;
    stb.popSt     = wbFire && arrivalMode && !st.ldAny;
  end

  assign errBadResp = respValid && (arrivalMode
                      ? (respLd ? st.ldFull : (respSt ? st.stFull : 1'b1))
                      : !st.respHit);

  assign incLd = issueFire && issueLd;
  assign incSt = issueFire && issueSt;
  assign decLd = wbFire && isLoadClass(wbKind);
  assign decSt = wbFire && (wbKind == OP_STORE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadCnt  <= '0;
      storeCnt <= '0;
    end else begin
      loadCnt  <= loadCnt + CW'(incLd) - CW'(decLd);
      storeCnt <= storeCnt + CW'(incSt) - CW'(decSt);
    end
  end

  // R8
  no_ld_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    decLd |-> loadCnt != '0);

  // R8
  no_st_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    decSt |-> storeCnt != '0);

  // R7
  ld_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadCnt <= CAP);

  // R7
  st_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeCnt <= CAP);
endmodule

// File: rtl/respOrderBuf.sv
module respOrderBuf
  import rob_pkg::*;
#(
  parameter int TAG_W      = 8,
  parameter int SLOT_DEPTH = 4,
  parameter int QUEUE_SIZE = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             arrivalMode,
  input  logic             issueValid,
  input  logic [TAG_W-1:0] issueTag,
  input  logic [1:0]       issueKind,
  output logic             issueReady,
  input  logic             respValid,
  input  logic [TAG_W-1:0] respTag,
  input  logic [1:0]       respKind,
  output logic             wbValid,
  input  logic             wbReady,
  output logic [TAG_W-1:0] wbTag,
  output logic [1:0]       wbKind,
  output logic             errBadResp
);
  robStrobe_t stb;
  robStatus_t st;

  rob_ctrl #(.QUEUE_SIZE(QUEUE_SIZE)) i_ctrl (
    .clk(clk), .rstN(rstN), .arrivalMode(arrivalMode),
    .issueValid(issueValid), .issueKind(issueKind),
    .respValid(respValid), .respKind(respKind),
    .wbReady(wbReady), .wbKind(wbKind), .st(st), .stb(stb),
    .issueReady(issueReady), .wbValid(wbValid), .errBadResp(errBadResp)
  );

  rob_data #(.TAG_W(TAG_W), .SLOT_DEPTH(SLOT_DEPTH), .QUEUE_SIZE(QUEUE_SIZE)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .issueTag(issueTag), .issueKind(issueKind),
    .respTag(respTag), .respKind(respKind),
    .st(st), .wbTag(wbTag), .wbKind(wbKind)
  );

  // R10
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!arrivalMode && wbValid && !wbReady) |=> (wbValid && $stable(wbTag) && $stable(wbKind)));
endmodule

// File: tb/test_respOrderBuf.sv
module test_respOrderBuf;
  localparam int TAG_W = 8;
  localparam int SLOTS = 4;
  localparam int QSZ   = 4;

  logic clk = 1'b0;
  logic rstN, arrivalMode, issueValid, respValid, wbReady;
  logic [TAG_W-1:0] issueTag, respTag, wbTag;
  logic [1:0] issueKind, respKind, wbKind;
  logic issueReady, wbValid, errBadResp;

  always #4 clk = ~clk;  // 125 MHz

  respOrderBuf #(.TAG_W(TAG_W), .SLOT_DEPTH(SLOTS), .QUEUE_SIZE(QSZ)) i_respOrderBuf (
    .clk(clk), .rstN(rstN), .arrivalMode(arrivalMode),
    .issueValid(issueValid), .issueTag(issueTag), .issueKind(issueKind),
    .issueReady(issueReady), .respValid(respValid), .respTag(respTag),
    .respKind(respKind), .wbValid(wbValid), .wbReady(wbReady),
    .wbTag(wbTag), .wbKind(wbKind), .errBadResp(errBadResp)
  );

  int nChk = 0, nFail = 0;
  bit finished = 0;
  int tagCtr;
  int kinds[4], order[4], tags[4], expQ[4];

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset(input logic mode);
    rstN = 1'b0; arrivalMode = mode;
    issueValid = 0; issueTag = '0; issueKind = '0;
    respValid = 0; respTag = '0; respKind = '0; wbReady = 0;
    repeat (3) step();
    rstN = 1'b1;
    step();
  endtask

  task automatic issue(input int tag, input int kind, input string req);
    issueValid = 1; issueTag = TAG_W'(tag); issueKind = 2'(kind);
    #1 chk(req, int'(issueReady), 1);
    step();
    issueValid = 0;
  endtask

  task automatic respond(input int tag, input int kind);
    respValid = 1; respTag = TAG_W'(tag); respKind = 2'(kind);
    #1 chk("R4 no error on valid response", int'(errBadResp), 0);
    step();
    respValid = 0;
  endtask

  task automatic drain(input int tag, input int kind, input string req);
    wbReady = 1;
    #1;
    chk(req, int'(wbValid), 1);
    chk(req, int'(wbTag), tag & 8'hff);
    chk(req, int'(wbKind), kind);
    step();
    wbReady = 0;
  endtask

  // factoradic permutation p of 0..3 into order[]
  task automatic makePerm(input int p);
    int avail[4];
    int r, f, idx, n;
    for (int i = 0; i < 4; i++) avail[i] = i;
    r = p; n = 4;
    for (int i = 0; i < 4; i++) begin
      f = 1;
      for (int k = 2; k <= 3 - i; k++) f = f * k;
      idx = r / f; r = r % f;
      order[i] = avail[idx];
      for (int k = idx; k < n - 1; k++) avail[k] = avail[k + 1];
      n--;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int oldestDone, k;
    tagCtr = 0;

    // ---------------- R1 reset state
    doReset(1'b0);
    chk("R1 wbValid after reset", int'(wbValid), 0);
    chk("R1 errBadResp after reset", int'(errBadResp), 0);
    for (int kd = 0; kd < 4; kd++) begin
      issueKind = 2'(kd);
      #1 chk("R1 issueReady after reset", int'(issueReady), 1);
    end

    // ---------------- R3: program order across all 24 response orders
    for (int p = 0; p < 24; p++) begin
      makePerm(p);
      for (int i = 0; i < 4; i++) begin
        kinds[i] = (p + i) % 3;  // 0 load, 1 store, 2 atomic
        tags[i] = (tagCtr + i) & 8'hff;
        issue(tags[i], kinds[i], "R2 slot issue ready");
      end
      tagCtr += 4;
      oldestDone = 0;
      for (int i = 0; i < 4; i++) begin
        respond(tags[order[i]], kinds[order[i]]);
        if (order[i] == 0) oldestDone = 1;
        chk("R3 wbValid only when oldest done", int'(wbValid), oldestDone);
      end
      for (int i = 0; i < 4; i++) drain(tags[i], kinds[i], "R3 program-order delivery");
      chk("R3 empty after drain", int'(wbValid), 0);
    end

    // ---------------- R2: fence takes no slot
    issue(tagCtr, 0, "R2 load issue");
    issue(tagCtr + 1, 3, "R2 fence issue");
    issue(tagCtr + 2, 1, "R2 store issue");
    respond(tagCtr + 2, 1);
    respond(tagCtr, 0);
    drain(tagCtr, 0, "R2 load retires");
    drain(tagCtr + 2, 1, "R2 store retires past fence");
    chk("R2 nothing left after fence", int'(wbValid), 0);
    tagCtr += 3;

    // ---------------- R4, R9, R10, R11
    for (int i = 0; i < 4; i++) begin
      tags[i] = (tagCtr + i) & 8'hff;
      kinds[i] = (i == 3) ? 1 : 0;
      issue(tags[i], kinds[i], "R9 fill slots");
    end
    tagCtr += 4;
    issueValid = 1; issueKind = 2'd0; issueTag = TAG_W'(tagCtr);
    #1 chk("R9 load stalls on full slots", int'(issueReady), 0);
    issueKind = 2'd1;
    #1 chk("R9 store stalls on full slots", int'(issueReady), 0);
    issueKind = 2'd3;
    #1 chk("R9 fence ready with full slots", int'(issueReady), 1);
    issueValid = 0;

    respValid = 1; respTag = TAG_W'(tags[0] + 9); respKind = 2'd0;
    #1 chk("R4 unknown tag flagged", int'(errBadResp), 1);
    step();
    respValid = 0;
    #1 chk("R4 unknown tag leaves state", int'(wbValid), 0);
    respond(tags[0], 0);
    respValid = 1; respTag = TAG_W'(tags[0]); respKind = 2'd0;
    #1 chk("R4 duplicate response flagged", int'(errBadResp), 1);
    step();
    respValid = 0;
    step(); step();
    chk("R10 offer holds without ready", int'(wbValid), 1);
    chk("R10 offered tag holds", int'(wbTag), tags[0]);
    // same-cycle retire of oldest and done-mark of next
    wbReady = 1; respValid = 1; respTag = TAG_W'(tags[1]); respKind = 2'd0;
    #1 chk("R11 oldest offered", int'(wbTag), tags[0]);
    step();
    wbReady = 0; respValid = 0;
    #1 chk("R11 next offered after overlap", int'(wbValid), 1);
    chk("R11 next tag", int'(wbTag), tags[1]);
    drain(tags[1], 0, "R11 second retires");
    respond(tags[3], 1);
    chk("R3 younger done waits", int'(wbValid), 0);
    respond(tags[2], 0);
    drain(tags[2], 0, "R3 third");
    drain(tags[3], 1, "R3 fourth");

    // ---------------- R5, R6: arrival order across all 24 orders
    doReset(1'b1);
    for (int p = 0; p < 24; p++) begin
      makePerm(p);
      kinds[0] = 0; kinds[1] = 2; kinds[2] = 1; kinds[3] = 1;
      for (int i = 0; i < 4; i++) begin
        tags[i] = (tagCtr + i) & 8'hff;
        issue(tags[i], kinds[i], "R5 arrival issue");
      end
      tagCtr += 4;
      for (int i = 0; i < 4; i++) begin
        respond(tags[order[i]], kinds[order[i]]);
        if (i == 0) chk("R5 wbValid after first response", int'(wbValid), 1);
      end
      k = 0;
      for (int i = 0; i < 4; i++) if (order[i] < 2) begin expQ[k] = order[i]; k++; end
      for (int i = 0; i < 4; i++) if (order[i] >= 2) begin expQ[k] = order[i]; k++; end
      for (int i = 0; i < 4; i++)
        drain(tags[expQ[i]], kinds[expQ[i]], "R6 loads first, each queue in arrival order");
      chk("R5 empty after drain", int'(wbValid), 0);
    end

    // ---------------- R7, R8 caps
    for (int i = 0; i < 4; i++) issue(tagCtr + i, (i % 2) * 2, "R7 load under cap");
    issueValid = 1; issueTag = TAG_W'(tagCtr + 8); issueKind = 2'd0;
    #1 chk("R7 load at cap stalls", int'(issueReady), 0);
    issueKind = 2'd2;
    #1 chk("R7 atomic at cap stalls", int'(issueReady), 0);
    issueKind = 2'd1;
    #1 chk("R7 store ready while loads capped", int'(issueReady), 1);
    issueKind = 2'd3;
    #1 chk("R7 fence ready at cap", int'(issueReady), 1);
    issueValid = 0;
    for (int i = 4; i < 8; i++) issue(tagCtr + i, 1, "R7 store under cap");
    issueValid = 1; issueKind = 2'd1;
    #1 chk("R7 store at cap stalls", int'(issueReady), 0);
    issueValid = 0;
    for (int i = 0; i < 8; i++) respond(tagCtr + i, (i < 4) ? (i % 2) * 2 : 1);
    wbReady = 1; issueValid = 1; issueKind = 2'd0; issueTag = TAG_W'(tagCtr + 8);
    #1 chk("R8 stalled in retire cycle", int'(issueReady), 0);
    chk("R8 retiring load", int'(wbTag), tagCtr & 8'hff);
    step();
    wbReady = 0;
    #1 chk("R8 ready after retire", int'(issueReady), 1);
    issueValid = 0;
    for (int i = 1; i < 8; i++) drain(tagCtr + i, (i < 4) ? (i % 2) * 2 : 1, "R6 cap drain");
    chk("R10 nothing left", int'(wbValid), 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule